// File: doc/BRIEF.md
# Write Command Dispatcher with Pull Tagging

This block sits between a shared memory command bus and the per-bank queues of one memory channel. It looks at every command on the bus and keeps only those whose channel-select address bits match this channel's number. Kept commands enter an inlet queue in arrival order. The command at the head of that queue is moved into the command queue of the bank that its address selects. When that command is a write, a pull request for its data is issued in the same cycle. The pull request carries the bank number and the length in words.

A write does not leave the head of the queue unless its bank has a free command slot and enough space in its data queue for the whole burst. That space is counted against a per-bank reservation. The reservation counts words already stored and words requested but not yet returned. For every pull that is issued, a tag queue records the bank and the length. Returned data words are written into the data queue of the bank named by the oldest tag. That tag is retired when the last word of its burst has arrived. Because the space was reserved in advance, returned data is never refused and has no ready signal. Reads and other non-write commands need only a free command slot.

The command bus is a broadcast with no per-channel ready. The arbiter must stop sending commands to this channel while `cmd_stall` is high. Pull requests and both per-bank outputs follow valid/ready rules:
- Once raised, valid stays high and the payload stays unchanged until ready is seen high at a clock edge.
- Valid never depends on ready.

Top module: `wr_cmd_dispatch`

## Requirements
- R1: A command is taken when `cmd_valid` is high and address bit 4 (the channel-select field, 1 bit at bit 4) equals the channel number 0. Any other command is ignored and never reaches a bank output.
- R2: Commands are handled strictly in the order they were taken. Each one appears on the output of bank `addr[6:5]` with its address, length and write flag unchanged. A bank command output holds until it is accepted.
- R3: `cmd_stall` is high exactly when the inlet queue holds 6 or more entries (depth 8 minus a reserve of 2).
- R4: `pull_valid` is high exactly when all of the following hold:
  - The inlet head is a write.
  - Its bank's command queue (depth 4) is not full.
  - The bank's reservation plus the head length does not exceed the data queue depth 8.
  - The tag queue (depth 8) is not full.

  `pull_bank` and `pull_len` give the head's bank and length. The write moves on the cycle `pull_valid` and `pull_ready` are both high.
- R5: A non-write at the inlet head moves to its bank whenever that bank's command queue is not full. It issues no pull request and ignores data space.
- R6: A bank's reservation grows by the length of each write dispatched to it and shrinks by one for each data word taken from its data output. A write that does not fit holds the head, and everything behind it waits.
- R7: Each returned data word (`pd_valid`) goes to the data queue of the bank of the oldest outstanding pull. That pull is retired after its length in words has arrived. Order is kept within each bank.
- R8: A bank data output holds its word until `bk_dat_ready` for that bank is seen high.
- R9: In reset, and in the first cycle after it, every valid output and `cmd_stall` are low and all queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present on the bus |
| cmd_wr | input | 1 | 1 = write, 0 = other command |
| cmd_addr | input | 16 | Command address |
| cmd_len | input | 3 | Length in data words (1 to 7) |
| cmd_stall | output | 1 | Arbiter must stop sending commands |
| pull_valid | output | 1 | Pull request valid |
| pull_ready | input | 1 | Pull request accepted |
| pull_bank | output | 2 | Bank the pulled data is for |
| pull_len | output | 3 | Words to pull |
| pd_valid | input | 1 | Returned data word valid |
| pd_data | input | 16 | Returned data word |
| bk_cmd_valid | output | 4 | Per-bank command valid |
| bk_cmd_ready | input | 4 | Per-bank command accept |
| bk_cmd_addr | output | 64 | Per-bank command address, bank b at bits [16b+15:16b] |
| bk_cmd_len | output | 12 | Per-bank command length, bank b at bits [3b+2:3b] |
| bk_cmd_wr | output | 4 | Per-bank command write flag |
| bk_dat_valid | output | 4 | Per-bank data word valid |
| bk_dat_ready | input | 4 | Per-bank data word accept |
| bk_dat_data | output | 64 | Per-bank data word, bank b at bits [16b+15:16b] |

## Verification
A miscounted reservation shows in the cycle it goes wrong. `pull_valid` is withheld or raised for a write whose fit in the data queue says otherwise, and the next command on that bank's output appears early or late. A wrong or stale tag head makes a returned word surface on another bank's data output once it reaches that queue's head. A wrong burst count does the same at the first word of the next burst. A wrong inlet count or a mistaken channel match shows as `cmd_stall` differing from the entry count within one cycle, or as an unexpected command at a bank output.

// File: rtl/wcd_pkg.sv
package wcd_pkg;
  typedef enum logic {OP_OTHER = 1'b0, OP_WRITE = 1'b1} wcd_op_e;

  // true when a burst of len words fits beside used words in a queue of cap
  function automatic logic wcd_fits(input int unsigned used,
                                    input int unsigned len,
                                    input int unsigned cap);
    return (used + len) <= cap;
  endfunction
endpackage

// File: rtl/wcd_fifo.sv
module wcd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/wcd_bank_lane.sv
module wcd_bank_lane #(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 3,
  parameter int DATA_W      = 16,
  parameter int CMDQ_DEPTH  = 4,
  parameter int DATAQ_DEPTH = 8,
  localparam int ENT_W      = 1 + LEN_W + ADDR_W,
  localparam int RESV_W     = $clog2(DATAQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cq_push,
  input  logic [ENT_W-1:0]  cq_din,
  output logic              cq_full,
  input  logic              res_add,
  input  logic [LEN_W-1:0]  res_len,
  input  logic              pd_push,
  input  logic [DATA_W-1:0] pd_din,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_wr,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [DATA_W-1:0] dat_data,
  output logic [RESV_W-1:0] resv,
  output logic [RESV_W-1:0] dq_count
);
  localparam int CQ_CW = $clog2(CMDQ_DEPTH + 1);

  logic [CQ_CW-1:0] cq_count;
  logic [ENT_W-1:0] cq_head;
  logic             word_out;

  wcd_fifo #(.W(ENT_W), .DEPTH(CMDQ_DEPTH)) u_cq (
    .clk(clk), .rst_n(rst_n), .push(cq_push), .din(cq_din),
    .pop(cmd_ready), .dout(cq_head), .count(cq_count));

  wcd_fifo #(.W(DATA_W), .DEPTH(DATAQ_DEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n), .push(pd_push), .din(pd_din),
    .pop(dat_ready), .dout(dat_data), .count(dq_count));

  assign cq_full   = (cq_count == CQ_CW'(CMDQ_DEPTH));
  assign cmd_valid = (cq_count != '0);
  assign {cmd_wr, cmd_len, cmd_addr} = cq_head;
  assign dat_valid = (dq_count != '0);
  assign word_out  = dat_valid && dat_ready;

  // space held for this bank: stored words plus words still being pulled
  always_ff @(posedge clk) begin
    if (!rst_n) resv <= '0;
    else        resv <= resv + (res_add ? RESV_W'(res_len) : '0) - RESV_W'(word_out);
  end
endmodule

// File: rtl/wr_cmd_dispatch.sv
module wr_cmd_dispatch
  import wcd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 3,
  parameter int DATA_W      = 16,
  parameter int NBANK       = 4,
  parameter int CH_LSB      = 4,
  parameter int CH_W        = 1,
  parameter int CHAN_ID     = 0,
  parameter int INLET_DEPTH = 8,
  parameter int SKID        = 2,
  parameter int CMDQ_DEPTH  = 4,
  parameter int DATAQ_DEPTH = 8,
  parameter int TAG_DEPTH   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic                       cmd_wr,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [LEN_W-1:0]           cmd_len,
  output logic                       cmd_stall,
  output logic                       pull_valid,
  input  logic                       pull_ready,
  output logic [$clog2(NBANK)-1:0]   pull_bank,
  output logic [LEN_W-1:0]           pull_len,
  input  logic                       pd_valid,
  input  logic [DATA_W-1:0]          pd_data,
  output logic [NBANK-1:0]           bk_cmd_valid,
  input  logic [NBANK-1:0]           bk_cmd_ready,
  output logic [NBANK*ADDR_W-1:0]    bk_cmd_addr,
  output logic [NBANK*LEN_W-1:0]     bk_cmd_len,
  output logic [NBANK-1:0]           bk_cmd_wr,
  output logic [NBANK-1:0]           bk_dat_valid,
  input  logic [NBANK-1:0]           bk_dat_ready,
  output logic [NBANK*DATA_W-1:0]    bk_dat_data
);
  localparam int BANK_W   = $clog2(NBANK);
  localparam int BANK_LSB = CH_LSB + CH_W;
  localparam int ENT_W    = 1 + LEN_W + ADDR_W;
  localparam int RESV_W   = $clog2(DATAQ_DEPTH + 1);
  localparam int IN_CW    = $clog2(INLET_DEPTH + 1);
  localparam int TAG_CW   = $clog2(TAG_DEPTH + 1);
  localparam int TAG_W    = BANK_W + LEN_W;

  // inlet queue
  logic              in_push, in_pop, in_empty;
  logic [IN_CW-1:0]  in_count;
  logic [ENT_W-1:0]  head;
  wcd_op_e           head_op;
  logic [LEN_W-1:0]  head_len;
  logic [ADDR_W-1:0] head_addr;
  logic [BANK_W-1:0] hb;

  assign in_push = cmd_valid && (cmd_addr[CH_LSB +: CH_W] == CH_W'(CHAN_ID));

  wcd_fifo #(.W(ENT_W), .DEPTH(INLET_DEPTH)) u_inlet (
    .clk(clk), .rst_n(rst_n), .push(in_push), .din({cmd_wr, cmd_len, cmd_addr}),
    .pop(in_pop), .dout(head), .count(in_count));

  assign in_empty  = (in_count == '0);
  assign cmd_stall = (in_count >= IN_CW'(INLET_DEPTH - SKID));
  assign head_op   = wcd_op_e'(head[ENT_W-1]);
  assign head_len  = head[ADDR_W +: LEN_W];
  assign head_addr = head[ADDR_W-1:0];
  assign hb        = head_addr[BANK_LSB +: BANK_W];

  // tag queue of outstanding pulls
  logic              tag_full, tag_empty, tag_pop, pull_fire;
  logic [TAG_CW-1:0] tag_count;
  logic [TAG_W-1:0]  tag_head;
  logic [BANK_W-1:0] tag_bank;
  logic [LEN_W-1:0]  tag_len, burst_q;

  wcd_fifo #(.W(TAG_W), .DEPTH(TAG_DEPTH)) u_tag (
    .clk(clk), .rst_n(rst_n), .push(pull_fire), .din({hb, head_len}),
    .pop(tag_pop), .dout(tag_head), .count(tag_count));

  assign tag_full  = (tag_count == TAG_CW'(TAG_DEPTH));
  assign tag_empty = (tag_count == '0);
  assign {tag_bank, tag_len} = tag_head;
  assign tag_pop   = pd_valid && !tag_empty && (burst_q == tag_len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                      burst_q <= '0;
    else if (tag_pop)                burst_q <= '0;
    else if (pd_valid && !tag_empty) burst_q <= burst_q + LEN_W'(1);
  end

  // bank lanes
  logic [NBANK-1:0]  cq_full, cq_push, res_add, pd_push;
  logic [RESV_W-1:0] resv   [NBANK];
  logic [RESV_W-1:0] dq_cnt [NBANK];
  logic [NBANK*RESV_W-1:0] resv_flat, dq_cnt_flat;
  logic              fits, other_go;

  assign fits       = wcd_fits(32'(resv[hb]), 32'(head_len), DATAQ_DEPTH);
  assign pull_valid = !in_empty && (head_op == OP_WRITE) && !cq_full[hb] && fits && !tag_full;
  assign other_go   = !in_empty && (head_op == OP_OTHER) && !cq_full[hb];
  assign pull_fire  = pull_valid && pull_ready;
  assign in_pop     = pull_fire || other_go;
  assign pull_bank  = hb;
  assign pull_len   = head_len;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      cq_push[b] = in_pop && (hb == BANK_W'(b));
      res_add[b] = pull_fire && (hb == BANK_W'(b));
      pd_push[b] = pd_valid && !tag_empty && (tag_bank == BANK_W'(b));
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_lane
    wcd_bank_lane #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
      .CMDQ_DEPTH(CMDQ_DEPTH), .DATAQ_DEPTH(DATAQ_DEPTH)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .cq_push(cq_push[b]), .cq_din(head), .cq_full(cq_full[b]),
      .res_add(res_add[b]), .res_len(head_len),
      .pd_push(pd_push[b]), .pd_din(pd_data),
      .cmd_valid(bk_cmd_valid[b]), .cmd_ready(bk_cmd_ready[b]),
      .cmd_addr(bk_cmd_addr[b*ADDR_W +: ADDR_W]),
      .cmd_len(bk_cmd_len[b*LEN_W +: LEN_W]), .cmd_wr(bk_cmd_wr[b]),
      .dat_valid(bk_dat_valid[b]), .dat_ready(bk_dat_ready[b]),
      .dat_data(bk_dat_data[b*DATA_W +: DATA_W]),
      .resv(resv[b]), .dq_count(dq_cnt[b]));
    assign resv_flat[b*RESV_W +: RESV_W]   = resv[b];
    assign dq_cnt_flat[b*RESV_W +: RESV_W] = dq_cnt[b];
  end
endmodule

// File: rtl/wcd_chk.sv
module wcd_chk #(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 3,
  parameter int DATA_W      = 16,
  parameter int NBANK       = 4,
  parameter int DATAQ_DEPTH = 8,
  localparam int RESV_W     = $clog2(DATAQ_DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pull_valid,
  input logic                    pull_ready,
  input logic [$clog2(NBANK)-1:0] pull_bank,
  input logic [LEN_W-1:0]        pull_len,
  input logic [NBANK-1:0]        bk_cmd_valid,
  input logic [NBANK-1:0]        bk_cmd_ready,
  input logic [NBANK*ADDR_W-1:0] bk_cmd_addr,
  input logic [NBANK*LEN_W-1:0]  bk_cmd_len,
  input logic [NBANK-1:0]        bk_cmd_wr,
  input logic [NBANK-1:0]        bk_dat_valid,
  input logic [NBANK-1:0]        bk_dat_ready,
  input logic [NBANK*DATA_W-1:0] bk_dat_data,
  input logic [NBANK*RESV_W-1:0] resv_flat,
  input logic [NBANK*RESV_W-1:0] dq_cnt_flat
);
  // R4
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_valid && !pull_ready |=> pull_valid && $stable(pull_bank) && $stable(pull_len));

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bk_cmd_valid[b] && !bk_cmd_ready[b] |=> bk_cmd_valid[b] &&
        $stable(bk_cmd_addr[b*ADDR_W +: ADDR_W]) && $stable(bk_cmd_len[b*LEN_W +: LEN_W]) &&
        $stable(bk_cmd_wr[b]));
    // R8
    dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bk_dat_valid[b] && !bk_dat_ready[b] |=> bk_dat_valid[b] &&
        $stable(bk_dat_data[b*DATA_W +: DATA_W]));
    // R6
    resv_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_cnt_flat[b*RESV_W +: RESV_W] <= resv_flat[b*RESV_W +: RESV_W]);
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resv_flat[b*RESV_W +: RESV_W] <= RESV_W'(DATAQ_DEPTH));
  end
endmodule

bind wr_cmd_dispatch wcd_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
  .NBANK(NBANK), .DATAQ_DEPTH(DATAQ_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .pull_valid(pull_valid), .pull_ready(pull_ready),
  .pull_bank(pull_bank), .pull_len(pull_len),
  .bk_cmd_valid(bk_cmd_valid), .bk_cmd_ready(bk_cmd_ready),
  .bk_cmd_addr(bk_cmd_addr), .bk_cmd_len(bk_cmd_len), .bk_cmd_wr(bk_cmd_wr),
  .bk_dat_valid(bk_dat_valid), .bk_dat_ready(bk_dat_ready), .bk_dat_data(bk_dat_data),
  .resv_flat(resv_flat), .dq_cnt_flat(dq_cnt_flat));

// File: tb/tb_wr_cmd_dispatch.sv
`timescale 1ns/1ps
module tb_wr_cmd_dispatch;
  localparam int NB = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_valid, cmd_wr, cmd_stall, pull_valid, pull_ready, pd_valid;
  logic [15:0] cmd_addr, pd_data;
  logic [2:0]  cmd_len, pull_len;
  logic [1:0]  pull_bank;
  logic [NB-1:0] bk_cmd_valid, bk_cmd_ready, bk_cmd_wr, bk_dat_valid, bk_dat_ready;
  logic [NB*16-1:0] bk_cmd_addr, bk_dat_data;
  logic [NB*3-1:0]  bk_cmd_len;

  wr_cmd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_stall(cmd_stall),
    .pull_valid(pull_valid), .pull_ready(pull_ready), .pull_bank(pull_bank),
    .pull_len(pull_len), .pd_valid(pd_valid), .pd_data(pd_data),
    .bk_cmd_valid(bk_cmd_valid), .bk_cmd_ready(bk_cmd_ready),
    .bk_cmd_addr(bk_cmd_addr), .bk_cmd_len(bk_cmd_len), .bk_cmd_wr(bk_cmd_wr),
    .bk_dat_valid(bk_dat_valid), .bk_dat_ready(bk_dat_ready), .bk_dat_data(bk_dat_data));

  int n_chk = 0, n_fail = 0;
  int accepted = 0, rejected = 0, delivered = 0;
  bit done = 0;

  // behavioural model state; entry = {wr, len[2:0], addr[15:0]}
  logic [19:0] mi [$];
  logic [19:0] mcq [NB][$];
  logic [15:0] mdq [NB][$];
  int mtag_b [$];
  int mtag_l [$];
  int mresv [NB];
  int mburst = 0;
  bit hold_prev [NB];
  logic [15:0] dcount = 16'h1000;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_fits();
    logic [19:0] h = mi[0];
    return (mresv[h[6:5]] + int'(h[18:16])) <= 8;
  endfunction

  function automatic bit m_pull();
    logic [19:0] h;
    if (mi.size() == 0) return 0;
    h = mi[0];
    return h[19] && (mcq[h[6:5]].size() < 4) && m_fits() && (mtag_b.size() < 8);
  endfunction

  function automatic bit m_empty();
    bit e = (mi.size() == 0) && (mtag_b.size() == 0);
    for (int b = 0; b < NB; b++) e = e && (mcq[b].size() == 0) && (mdq[b].size() == 0);
    return e;
  endfunction

  task automatic compare();
    logic [19:0] h;
    bit ev;
    string tg;
    check(cmd_stall == (mi.size() >= 6), "R3", "cmd_stall", cmd_stall, mi.size() >= 6);
    ev = m_pull();
    tg = "R4";
    if (mi.size() > 0 && mi[0][19] && !m_fits()) tg = "R6";
    check(pull_valid == ev, tg, "pull_valid", pull_valid, ev);
    if (ev && pull_valid)
      check({pull_bank, pull_len} == {mi[0][6:5], mi[0][18:16]}, "R4", "pull bank/len",
            {pull_bank, pull_len}, {mi[0][6:5], mi[0][18:16]});
    for (int b = 0; b < NB; b++) begin
      ev = mcq[b].size() > 0;
      tg = (ev && !mcq[b][0][19]) ? "R5" : "R2";
      check(bk_cmd_valid[b] == ev, tg, $sformatf("bank%0d cmd valid", b), bk_cmd_valid[b], ev);
      if (ev && bk_cmd_valid[b]) begin
        h = mcq[b][0];
        check({bk_cmd_wr[b], bk_cmd_len[b*3 +: 3], bk_cmd_addr[b*16 +: 16]} == h, tg,
              $sformatf("bank%0d cmd", b),
              {bk_cmd_wr[b], bk_cmd_len[b*3 +: 3], bk_cmd_addr[b*16 +: 16]}, h);
      end
      ev = mdq[b].size() > 0;
      tg = hold_prev[b] ? "R8" : "R7";
      check(bk_dat_valid[b] == ev, tg, $sformatf("bank%0d dat valid", b), bk_dat_valid[b], ev);
      if (ev && bk_dat_valid[b])
        check(bk_dat_data[b*16 +: 16] == mdq[b][0], tg, $sformatf("bank%0d data", b),
              bk_dat_data[b*16 +: 16], mdq[b][0]);
    end
  endtask

  task automatic model_step();
    logic [19:0] h;
    int pre_in = mi.size();
    bit go = 0;
    int hbk = 0;
    if (pre_in > 0) begin
      h = mi[0];
      hbk = h[6:5];
      go = h[19] ? (m_pull() && pull_ready) : (mcq[hbk].size() < 4);
    end
    for (int b = 0; b < NB; b++) begin
      if (bk_cmd_ready[b] && mcq[b].size() > 0) void'(mcq[b].pop_front());
      if (bk_dat_ready[b] && mdq[b].size() > 0) begin
        void'(mdq[b].pop_front());
        mresv[b]--;
      end
    end
    if (pd_valid && mtag_b.size() > 0) begin
      mdq[mtag_b[0]].push_back(pd_data);
      mburst++;
      if (mburst == mtag_l[0]) begin
        void'(mtag_b.pop_front());
        void'(mtag_l.pop_front());
        mburst = 0;
      end
    end
    if (go) begin
      void'(mi.pop_front());
      mcq[hbk].push_back(h);
      if (h[19]) begin
        mresv[hbk] += int'(h[18:16]);
        mtag_b.push_back(hbk);
        mtag_l.push_back(int'(h[18:16]));
      end
    end
    if (cmd_valid) begin
      if (cmd_addr[4] == 1'b0) begin
        if (pre_in < 8) mi.push_back({cmd_wr, cmd_len, cmd_addr});
        accepted++;
      end else rejected++;
    end
  endtask

  function automatic bit chance(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic drive(input int ph);
    int pc, pr, pdp, rd;
    pc  = (ph == 0) ? 60 : (ph == 1) ? 80 : (ph == 2) ? 70 : 0;
    pr  = (ph == 3) ? 100 : 60;
    pdp = (ph == 3) ? 100 : 70;
    cmd_valid = 1'b0;
    if (!cmd_stall && chance(pc)) begin
      cmd_valid = 1'b1;
      cmd_addr  = 16'($urandom);
      cmd_addr[4] = chance(85) ? 1'b0 : 1'b1;
      cmd_wr    = chance(60);
      cmd_len   = 3'(1 + ($urandom % 7));
      if (ph == 2) begin
        cmd_addr[6:5] = 2'd0;
        cmd_wr  = 1'b1;
        cmd_len = 3'(5 + ($urandom % 3));
      end
    end
    pull_ready = chance(pr);
    pd_valid = 1'b0;
    if (mtag_b.size() > 0 && chance(pdp)) begin
      pd_valid = 1'b1;
      pd_data  = dcount;
      dcount   = dcount + 16'd1;
    end
    for (int b = 0; b < NB; b++) begin
      rd = (ph == 0) ? 50 : (ph == 1) ? 0 : (ph == 2) ? 50 : 100;
      bk_cmd_ready[b] = chance(rd);
      bk_dat_ready[b] = chance((ph == 2) ? 20 : rd);
      if (bk_cmd_ready[b] && bk_cmd_valid[b]) delivered++;
      hold_prev[b] = bk_dat_valid[b] && !bk_dat_ready[b];
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    for (int b = 0; b < NB; b++) begin
      mresv[b] = 0;
      hold_prev[b] = 0;
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_wr = 1'b0; cmd_addr = '0; cmd_len = 3'd1;
    pull_ready = 1'b0; pd_valid = 1'b0; pd_data = '0; bk_cmd_ready = '0; bk_dat_ready = '0;
    repeat (5) @(negedge clk);
    // R9: outputs idle in reset
    check({cmd_stall, pull_valid, bk_cmd_valid, bk_dat_valid} == '0, "R9", "reset outputs",
          {cmd_stall, pull_valid, bk_cmd_valid, bk_dat_valid}, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 8000; cyc++) begin
      int ph;
      ph = (cyc < 3000) ? 0 : (cyc < 3600) ? 1 : (cyc < 5000) ? 2 : 3;
      if (ph == 3 && m_empty()) break;
      compare();
      drive(ph);
      model_step();
      @(negedge clk);
    end
    compare();
    check(m_empty(), "R7", "all traffic drained", m_empty(), 1);
    // R1: only matching commands reached the banks
    check(delivered == accepted, "R1", "commands delivered", delivered, accepted);
    check(rejected > 0, "R1", "foreign commands seen", rejected, 1);
    check({cmd_stall, pull_valid, bk_cmd_valid, bk_dat_valid} == '0, "R9", "idle after drain",
          {cmd_stall, pull_valid, bk_cmd_valid, bk_dat_valid}, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule